// File: doc/BRIEF.md
# Oscillator Frequency Meter

This block measures how fast one of two free-running oscillator clocks is ticking. A fixed gate window is timed in reference-clock ticks. During that window the chosen oscillator's edges are counted in its own clock domain. When the window closes, the count is carried back to the reference domain and becomes the result. The window length is a parameter of 1024 ticks. With a 26 MHz reference, the frequency in MHz is therefore `count * 26 / 1024`, scaled by the divisor when one is set.

Control follows a register-style discipline. The meter enable must already be high before a start request is accepted. After a request is accepted, `busy` stays high until the result is loaded, and it then drops on its own. A 2-bit mode field must hold 00 for a source code to be taken. An 8-bit divisor thins the count, and zero means every oscillator cycle is counted. Dropping the enable at any time returns the meter to idle. If a measurement is running when this happens, it is abandoned and the old result is kept.

The reference-domain controller is a four-state machine:
- ST_OFF: the enable is low.
- ST_READY: the meter is enabled and idle.
- ST_GATE: the window is open.
- ST_COLLECT: the window is closed and the meter is waiting for the count to return.

The transitions are:
- OFF→READY when the enable is high.
- READY→GATE on an accepted start request.
- GATE→COLLECT when the last window tick is reached.
- COLLECT→READY when the count arrives; this is the capture.
- READY, GATE or COLLECT → OFF whenever the enable is low; from GATE or COLLECT this is an abort.

Each oscillator has its own counting slice. The gate level is synchronized into the slice's domain, and the slice reports completion by flipping a toggle that is synchronized back.

Top module: `osc_freq_meter`

## Requirements
- R1: With the divisor at 0, the result equals the number of oscillator cycles in a window of WINDOW reference cycles, to within ±3 counts.
- R2: `run_req` is accepted only in a cycle in which the meter was already enabled. A request in a cycle with `meter_en` low, or in the same cycle as the enable's first high cycle, leaves `busy` low.
- R3: `busy` goes high on the clock edge after an accepted request. It falls by itself on the same edge at which `count` takes the new result. `count` changes on no other edge.
- R4: While the meter is idle and `mode_sel` is 00, the source code 6'h21 selects `osc_a` and 6'h22 selects `osc_b`. Any other code leaves the current choice unchanged. After reset `osc_a` is selected.
- R5: While `mode_sel` is not 00, a source code has no effect on the choice of oscillator.
- R6: With a divisor value N (latched when the request is accepted), the result counts one step per N+1 oscillator cycles, to within ±3. N = 0 counts every cycle.
- R7: If `meter_en` is low during a measurement, `busy` is low on the next edge and `count` keeps its previous value.
- R8: The count saturates at all ones and never wraps.
- R9: After reset, `busy` is 0 and `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a | input | 1 | First oscillator under measurement |
| osc_b | input | 1 | Second oscillator under measurement |
| meter_en | input | 1 | Meter enable |
| run_req | input | 1 | Start request, one-cycle pulse |
| mode_sel | input | 2 | Mode field; 00 lets the source code through |
| src_sel | input | 6 | Source code: 6'h21 = osc_a, 6'h22 = osc_b |
| divisor | input | DIV_W | Count divisor, 0 = count every cycle |
| busy | output | 1 | High while a measurement is in progress |
| count | output | CNT_W | Last completed result |

## Verification
The enable and a start request can land in the same cycle. The rule that the enable must come first is judged at that overlap: the bench raises `meter_en` and pulses `run_req` on the same edge, and `busy` must remain low. A second collision is an abort against a measurement in flight. The bench drops the enable mid-window, expects `busy` low one edge later, and checks that the late toggle from the aborted slice does not overwrite the held result, both before and after re-enabling.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_READY,
        ST_GATE,
        ST_COLLECT
    } fm_state_e;

    localparam int NUM_SRC = 2;
    localparam int SRC_W   = 1;

    localparam logic [5:0] SRC_CODE_A   = 6'h21;
    localparam logic [5:0] SRC_CODE_B   = 6'h22;
    localparam logic [1:0] MODE_MEASURE = 2'b00;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_osc_slice.sv
module fm_osc_slice #(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_ref,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] hold,
    output logic             done_tgl
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             g_s;
    logic             g_d;
    logic [DIV_W-1:0] pre;
    logic [CNT_W-1:0] cnt;

    fm_sync #(.STAGES(STAGES)) u_gate_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (gate_ref),
        .q     (g_s)
    );

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            g_d      <= 1'b0;
            pre      <= '0;
            cnt      <= '0;
            hold     <= '0;
            done_tgl <= 1'b0;
        end else begin
            g_d <= g_s;
            if (g_s && !g_d) begin
                cnt <= '0;
                pre <= '0;
            end else if (g_s) begin
                if (pre == div) begin
                    pre <= '0;
                    if (cnt != CNT_MAX) begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    pre <= pre + 1'b1;
                end
            end
            if (!g_s && g_d) begin
                hold     <= cnt;
                done_tgl <= ~done_tgl;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (g_s && g_d && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R8
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
    import fm_pkg::*;
#(
    parameter int WINDOW = 1024,
    parameter int DIV_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meter_en,
    input  logic               run_req,
    input  logic [1:0]         mode_sel,
    input  logic [5:0]         src_sel,
    input  logic [DIV_W-1:0]   divisor,
    input  logic [NUM_SRC-1:0] res_arrive,
    output logic               busy,
    output logic               capture,
    output logic [NUM_SRC-1:0] gate_vec,
    output logic [SRC_W-1:0]   src_idx,
    output logic [DIV_W-1:0]   div_q
);
    localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(WINDOW - 1);

    fm_state_e state, state_nxt;
    logic [TW-1:0] tick;
    logic          arrive_sel;
    logic          gate_on;

    assign arrive_sel = res_arrive[src_idx];

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (meter_en) state_nxt = ST_READY;
            end
            ST_READY: begin
                if (!meter_en)    state_nxt = ST_OFF;
                else if (run_req) state_nxt = ST_GATE;
            end
            ST_GATE: begin
                if (!meter_en)              state_nxt = ST_OFF;
                else if (tick == TICK_LAST) state_nxt = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!meter_en)       state_nxt = ST_OFF;
                else if (arrive_sel) state_nxt = ST_READY;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        busy    = (state == ST_GATE) || (state == ST_COLLECT);
        gate_on = (state == ST_GATE);
        capture = (state == ST_COLLECT) && meter_en && arrive_sel;
        for (int i = 0; i < NUM_SRC; i++) begin
            gate_vec[i] = gate_on && (src_idx == SRC_W'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick    <= '0;
            src_idx <= '0;
            div_q   <= '0;
        end else begin
            tick <= gate_on ? tick + 1'b1 : '0;
            if (!busy && mode_sel == MODE_MEASURE) begin
                if (src_sel == SRC_CODE_A)      src_idx <= SRC_W'(0);
                else if (src_sel == SRC_CODE_B) src_idx <= SRC_W'(1);
            end
            if (state == ST_READY && meter_en && run_req) begin
                div_q <= divisor;
            end
        end
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(run_req) && $past(meter_en))); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !meter_en |=> !busy); // R7
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_on) && $past(meter_en)) |-> ($past(tick) == TICK_LAST)); // R1
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
    import fm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 8,
    parameter int WINDOW      = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             osc_a,
    input  logic             osc_b,
    input  logic             meter_en,
    input  logic             run_req,
    input  logic [1:0]       mode_sel,
    input  logic [5:0]       src_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             busy,
    output logic [CNT_W-1:0] count
);
    logic [NUM_SRC-1:0] osc_clks;
    logic [NUM_SRC-1:0] gate_vec;
    logic [NUM_SRC-1:0] tgl_osc;
    logic [NUM_SRC-1:0] tgl_ref;
    logic [NUM_SRC-1:0] tgl_prev;
    logic [NUM_SRC-1:0] res_arrive;
    logic [CNT_W-1:0]   hold [NUM_SRC];
    logic [SRC_W-1:0]   src_idx;
    logic [DIV_W-1:0]   div_q;
    logic               capture;

    assign osc_clks   = {osc_b, osc_a};
    assign res_arrive = tgl_ref ^ tgl_prev;

    fm_ctrl #(.WINDOW(WINDOW), .DIV_W(DIV_W)) u_ctrl (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .meter_en   (meter_en),
        .run_req    (run_req),
        .mode_sel   (mode_sel),
        .src_sel    (src_sel),
        .divisor    (divisor),
        .res_arrive (res_arrive),
        .busy       (busy),
        .capture    (capture),
        .gate_vec   (gate_vec),
        .src_idx    (src_idx),
        .div_q      (div_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fm_osc_slice #(.CNT_W(CNT_W), .DIV_W(DIV_W), .STAGES(SYNC_STAGES)) u_slice (
            .osc_clk  (osc_clks[g]),
            .rst_n    (rst_n),
            .gate_ref (gate_vec[g]),
            .div      (div_q),
            .hold     (hold[g]),
            .done_tgl (tgl_osc[g])
        );
        fm_sync #(.STAGES(SYNC_STAGES)) u_ret_sync (
            .clk   (clk_ref),
            .rst_n (rst_n),
            .d     (tgl_osc[g]),
            .q     (tgl_ref[g])
        );
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            tgl_prev <= '0;
            count    <= '0;
        end else begin
            tgl_prev <= tgl_ref;
            if (capture) begin
                count <= hold[src_idx];
            end
        end
    end

    AST_RESULT_ON_DONE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$stable(count) |-> $fell(busy)); // R3
endmodule

// File: tb/sim_osc_freq_meter.sv
`timescale 1ns/1ps
module sim_osc_freq_meter;
    localparam int CNT_W = 12;

    logic             clk_ref = 1'b0;
    logic             osc_a   = 1'b0;
    logic             osc_b   = 1'b0;
    logic             rst_n   = 1'b0;
    logic             meter_en = 1'b0;
    logic             run_req  = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic [5:0]       src_sel  = 6'h00;
    logic [7:0]       divisor  = 8'd0;
    logic             busy;
    logic [CNT_W-1:0] count;

    int n_vec = 0;
    int n_bad = 0;
    int q_exp[$];
    int q_tol[$];
    string q_tag[$];
    logic busy_prev = 1'b0;

    always #10 clk_ref = ~clk_ref;
    always #2  osc_a   = ~osc_a;
    always #5  osc_b   = ~osc_b;

    osc_freq_meter #(.CNT_W(CNT_W)) u0 (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .osc_a    (osc_a),
        .osc_b    (osc_b),
        .meter_en (meter_en),
        .run_req  (run_req),
        .mode_sel (mode_sel),
        .src_sel  (src_sel),
        .divisor  (divisor),
        .busy     (busy),
        .count    (count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per completed measurement
    always @(negedge clk_ref) begin
        if (rst_n) begin
            if (busy_prev && !busy && q_exp.size() > 0) begin
                int e, t, a;
                string tg;
                e  = q_exp.pop_front();
                t  = q_tol.pop_front();
                tg = q_tag.pop_front();
                a  = int'(count);
                check((a >= e - t) && (a <= e + t), tg, a, e);
            end
            busy_prev = busy;
        end
    end

    task automatic measure(input logic [5:0] s, input logic [1:0] m, input logic [7:0] d,
                           input int exp, input int tol, input string tag);
        @(negedge clk_ref);
        src_sel  = s;
        mode_sel = m;
        divisor  = d;
        @(negedge clk_ref);
        q_exp.push_back(exp);
        q_tol.push_back(tol);
        q_tag.push_back(tag);
        run_req = 1'b1;
        @(negedge clk_ref);
        run_req = 1'b0;
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk_ref);
        @(negedge clk_ref);
    endtask

    initial begin
        repeat (200000) @(posedge clk_ref);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_ref);
        check(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk_ref);
        check(busy == 1'b0,  "R9 busy after reset", int'(busy), 0);
        check(count == '0,  "R9 count after reset", int'(count), 0);

        // R2: request while disabled
        run_req = 1'b1;
        @(negedge clk_ref);
        run_req = 1'b0;
        @(negedge clk_ref);
        check(busy == 1'b0, "R2 run while disabled", int'(busy), 0);

        // R2: enable and request in the same cycle
        meter_en = 1'b1;
        run_req  = 1'b1;
        @(negedge clk_ref);
        run_req = 1'b0;
        check(busy == 1'b0, "R2 run with enable same cycle", int'(busy), 0);
        @(negedge clk_ref);
        check(busy == 1'b0, "R2 still idle", int'(busy), 0);

        // osc_a: 1024*20/4 = 5120 -> saturates
        measure(6'h21, 2'b00, 8'd0, 4095, 0, "R8 saturate osc_a");
        measure(6'h21, 2'b00, 8'd1, 2560, 3, "R6 osc_a divisor 1");
        measure(6'h22, 2'b00, 8'd0, 2048, 3, "R4 R1 osc_b divisor 0");
        measure(6'h22, 2'b00, 8'd3, 512,  3, "R6 osc_b divisor 3");
        measure(6'h21, 2'b01, 8'd3, 512,  3, "R5 mode not 00 keeps osc_b");
        measure(6'h3F, 2'b00, 8'd0, 2048, 3, "R4 unknown code keeps osc_b");

        // R7: abort in the middle of a window
        @(negedge clk_ref);
        src_sel  = 6'h21;
        mode_sel = 2'b00;
        divisor  = 8'd1;
        @(negedge clk_ref);
        run_req = 1'b1;
        @(negedge clk_ref);
        run_req = 1'b0;
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        repeat (300) @(negedge clk_ref);
        meter_en = 1'b0;
        @(negedge clk_ref);
        check(busy == 1'b0, "R7 busy after abort", int'(busy), 0);
        check((int'(count) >= 2045) && (int'(count) <= 2051), "R7 count kept", int'(count), 2048);
        repeat (20) @(negedge clk_ref);
        meter_en = 1'b1;
        repeat (3) @(negedge clk_ref);
        check(busy == 1'b0, "R7 idle after re-enable", int'(busy), 0);
        check((int'(count) >= 2045) && (int'(count) <= 2051), "R7 count kept after re-enable", int'(count), 2048);

        measure(6'h21, 2'b00, 8'd1, 2560, 3, "R1 measure after abort");
        measure(6'h22, 2'b00, 8'd0, 2048, 3, "R1 osc_b repeat");

        check(q_exp.size() == 0, "R3 all results seen", q_exp.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule